// File: doc/BRIEF.md
# Word Load/Store Access Unit

This block connects a register datapath to a byte-addressed data memory and carries out whole-word loads and stores. Each request brings a base value, a signed 16-bit displacement, a register index and, for stores, the word to write. The unit adds the displacement to the base to form the access address. It rejects any word access whose address is not a multiple of four. It then places the four bytes of the word on the memory byte lanes in little-endian or big-endian order, as chosen by a run-time configuration input.

Requests use a valid/ready handshake, and only one access is in flight at a time. A store goes out in the same cycle it is accepted. A load also issues in its acceptance cycle. Its data comes back through the memory's valid strobe, and the unit presents it as a write-back word together with the destination index. A misaligned request produces a one-cycle error pulse. It has no other effect.

Top module: `ldst_unit`

## Requirements
- R1: The access address is the base plus the 16-bit offset sign-extended to 32 bits, wrapping modulo 2^32. For an aligned access, mem_addr equals that address in the acceptance cycle.
- R2: An accepted aligned store drives mem_req high and mem_we to 4'b1111 in its acceptance cycle, with its data on mem_wdata.
- R3: An accepted aligned load drives mem_req high with mem_we at zero. In the cycle in which mem_rvalid answers, wb_valid is high, wb_reg carries the destination index and wb_data carries the assembled word.
- R4: Memory lane k (mem_we[k], bits 8k+7:8k of mem_wdata and mem_rdata) holds the byte at address mem_addr+k. With cfg_big_endian=0, lane k carries word bits 8k+7:8k. With cfg_big_endian=1, lane k carries word bits 8(3-k)+7:8(3-k). This holds for both stores and loads.
- R5: A request whose address has either of its two low bits set raises no mem_req, drives mem_we to zero and produces no write-back. It leaves memory unchanged. align_err is high in the cycle after acceptance, and in that cycle only.
- R6: While a load waits for its data, req_ready is low. A request presented then is not issued to memory.
- R7: A load to register index 0 still issues its memory read, but wb_valid stays low.
- R8: A load uses the byte order in force when it was accepted. A change of cfg_big_endian while the load is pending does not affect its wb_data.
- R9: After reset is released and synchronised, req_ready is high and mem_req, align_err and wb_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_endian | input | 1 | Byte order: 0 little-endian, 1 big-endian |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can accept a request |
| req_store | input | 1 | 1 store, 0 load |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_reg | input | 5 | Destination (load) or source (store) register index |
| req_wdata | input | 32 | Store word |
| mem_req | output | 1 | Memory access strobe |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_we | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Store data in lane order |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data in lane order |
| wb_valid | output | 1 | Register write-back enable |
| wb_reg | output | 5 | Write-back register index |
| wb_data | output | 32 | Write-back word |
| align_err | output | 1 | Misaligned access pulse |

## Verification
Stores and loads are tried in both byte orders. Each round trip writes in one order and reads in the other, so a lane swap is visible that a symmetric error would hide. Positive, negative and wrapping displacements separate sign extension from zero extension and expose a carry lost at bit 32. Misaligned offsets, a load to index 0, and a request held through a pending load that flips the byte order mid-flight each target one control path. A later load then confirms that no stray write reached memory.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  // Byte ordering used to place word bytes on memory lanes
  typedef enum logic {
    ORDER_LITTLE = 1'b0,
    ORDER_BIG    = 1'b1
  } byte_order_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int BYTES  = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              aligned_o
);
  localparam int LOW_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] offset_ext;

  // Sign-extend the displacement, then add with natural wrap
  always_comb begin
    offset_ext  = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    eff_addr_o  = base_i + offset_ext;
    aligned_o   = (eff_addr_o[LOW_W-1:0] == '0);
    word_addr_o = {eff_addr_o[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/ldst_lane_map.sv
module ldst_lane_map
  import ldst_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  byte_order_e             order_i,
  input  logic [BYTES*BYTE_W-1:0] word_i,
  output logic [BYTES*BYTE_W-1:0] lanes_o
);
  // Lane k pairs with byte k (little) or byte BYTES-1-k (big).
  // The mapping is its own inverse, so one block serves both directions.
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    always_comb begin
      if (order_i == ORDER_BIG)
        lanes_o[k*BYTE_W +: BYTE_W] = word_i[(BYTES-1-k)*BYTE_W +: BYTE_W];
      else
        lanes_o[k*BYTE_W +: BYTE_W] = word_i[k*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_i_n,
  input  logic             req_valid_i,
  input  logic             req_store_i,
  input  logic [IDX_W-1:0] req_reg_i,
  input  byte_order_e      req_order_i,
  input  logic             aligned_i,
  input  logic             mem_rvalid_i,
  output logic             req_ready_o,
  output logic             issue_o,
  output logic             pend_o,
  output logic [IDX_W-1:0] pend_reg_o,
  output byte_order_e      pend_order_o,
  output logic             err_o
);
  logic             pend_q, pend_d;
  logic [IDX_W-1:0] pend_reg_q, pend_reg_d;
  byte_order_e      pend_order_q, pend_order_d;
  logic             err_q, err_d;
  logic             accept, load_issue, capture_en;

  // Next-state logic
  always_comb begin
    req_ready_o  = ~pend_q;
    accept       = req_valid_i & req_ready_o;
    issue_o      = accept & aligned_i;
    load_issue   = issue_o & ~req_store_i;
    capture_en   = load_issue;
    err_d        = accept & ~aligned_i;
    if (pend_q) pend_d = ~mem_rvalid_i;
    else        pend_d = load_issue;
    pend_reg_d   = capture_en ? req_reg_i   : pend_reg_q;
    pend_order_d = capture_en ? req_order_i : pend_order_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pend_q       <= 1'b0;
      pend_reg_q   <= '0;
      pend_order_q <= ORDER_LITTLE;
      err_q        <= 1'b0;
    end else begin
      pend_q       <= pend_d;
      pend_reg_q   <= pend_reg_d;
      pend_order_q <= pend_order_d;
      err_q        <= err_d;
    end
  end

  always_comb begin
    pend_o       = pend_q;
    pend_reg_o   = pend_reg_q;
    pend_order_o = pend_order_q;
    err_o        = err_q;
  end

  // R6: a load still waiting keeps the port closed next cycle
  p_stall_pending_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pend_q && !mem_rvalid_i) |=> !req_ready_o);

  // R5: the error pulse traces back to a misaligned acceptance
  p_err_source_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    err_q |-> $past(req_valid_i && req_ready_o && !aligned_i));

  // R8: captured byte order is held while the load is outstanding
  p_order_hold_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pend_q && !mem_rvalid_i) |=> $stable(pend_order_q));
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int BYTES  = 4,
  parameter int IDX_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_big_endian,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_store,
  input  logic [ADDR_W-1:0]       req_base,
  input  logic [OFF_W-1:0]        req_offset,
  input  logic [IDX_W-1:0]        req_reg,
  input  logic [BYTES*8-1:0]      req_wdata,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [BYTES-1:0]        mem_we,
  output logic [BYTES*8-1:0]      mem_wdata,
  input  logic                    mem_rvalid,
  input  logic [BYTES*8-1:0]      mem_rdata,
  output logic                    wb_valid,
  output logic [IDX_W-1:0]        wb_reg,
  output logic [BYTES*8-1:0]      wb_data,
  output logic                    align_err
);
  localparam int LOW_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  // Reset: asserts at once, releases after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [ADDR_W-1:0] eff_addr, word_addr;
  logic              aligned;
  logic              ctrl_ready, issue, pend;
  logic [IDX_W-1:0]  pend_reg;
  byte_order_e       cur_order, pend_order;
  logic [BYTES*8-1:0] store_lanes, load_word;

  assign cur_order = byte_order_e'(cfg_big_endian);

  ldst_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BYTES(BYTES)) u_agen (
    .base_i      (req_base),
    .offset_i    (req_offset),
    .eff_addr_o  (eff_addr),
    .word_addr_o (word_addr),
    .aligned_o   (aligned)
  );

  ldst_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst_i_n      (rst_i_n),
    .req_valid_i  (req_valid & rst_i_n),
    .req_store_i  (req_store),
    .req_reg_i    (req_reg),
    .req_order_i  (cur_order),
    .aligned_i    (aligned),
    .mem_rvalid_i (mem_rvalid),
    .req_ready_o  (ctrl_ready),
    .issue_o      (issue),
    .pend_o       (pend),
    .pend_reg_o   (pend_reg),
    .pend_order_o (pend_order),
    .err_o        (align_err)
  );

  ldst_lane_map #(.BYTES(BYTES)) u_store_map (
    .order_i (cur_order),
    .word_i  (req_wdata),
    .lanes_o (store_lanes)
  );

  ldst_lane_map #(.BYTES(BYTES)) u_load_map (
    .order_i (pend_order),
    .word_i  (mem_rdata),
    .lanes_o (load_word)
  );

  always_comb begin
    req_ready = ctrl_ready & rst_i_n;
    mem_req   = issue;
    mem_addr  = word_addr;
    mem_we    = (issue && req_store) ? {BYTES{1'b1}} : '0;
    mem_wdata = store_lanes;
    wb_valid  = pend & mem_rvalid & (pend_reg != '0);
    wb_reg    = pend_reg;
    wb_data   = load_word;
  end

  // R5: misaligned requests never reach memory
  p_no_access_misaligned_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && !aligned) |-> (!mem_req && mem_we == '0));

  // R1: memory sees only word-aligned addresses
  p_word_addr_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_req |-> (mem_addr[LOW_W-1:0] == '0 && mem_addr == eff_addr));

  // R7: index 0 never gets a write-back
  p_r0_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    wb_valid |-> (wb_reg != '0));

  // R2: an issued store enables every lane
  p_store_all_lanes_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mem_req && req_store) |-> (&mem_we));

  // R3: write-back appears only for an outstanding load
  p_wb_needs_pending_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    wb_valid |-> (pend && mem_rvalid));
endmodule

// File: tb/ldst_unit_bench.sv
module ldst_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_big_endian;
  logic        req_valid, req_ready, req_store;
  logic [31:0] req_base;
  logic [15:0] req_offset;
  logic [4:0]  req_reg;
  logic [31:0] req_wdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        wb_valid;
  logic [4:0]  wb_reg;
  logic [31:0] wb_data;
  logic        align_err;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ldst_unit u_ldst_unit (.*);

  // Memory model driven by the design's bus
  logic [7:0] dut_mem [logic [31:0]];
  logic [7:0] ref_mem [logic [31:0]];

  function automatic logic [7:0] fill(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rd_dut(input logic [31:0] a);
    return dut_mem.exists(a) ? dut_mem[a] : fill(a);
  endfunction

  function automatic logic [7:0] rd_ref(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : fill(a);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        if (mem_we == 4'b0000) begin
          mem_rvalid <= 1'b1;
          for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] <= rd_dut(mem_addr + 32'(k));
        end else begin
          for (int k = 0; k < 4; k++)
            if (mem_we[k]) dut_mem[mem_addr + 32'(k)] = mem_wdata[8*k +: 8];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Byte of a word that belongs at address offset k under the given order
  function automatic logic [7:0] word_byte(input logic [31:0] w, input int k, input bit be);
    return be ? w[8*(3-k) +: 8] : w[8*k +: 8];
  endfunction

  function automatic logic [31:0] ref_load(input logic [31:0] a, input bit be);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) begin
      if (be) w[8*(3-k) +: 8] = rd_ref(a + 32'(k));
      else    w[8*k +: 8]     = rd_ref(a + 32'(k));
    end
    return w;
  endfunction

  task automatic do_req(input bit st, input logic [31:0] base, input logic [15:0] off,
                        input logic [4:0] idx, input logic [31:0] data, input bit be);
    logic [31:0] ea;
    logic [31:0] exp_lanes;
    logic [31:0] exp_load;
    bit          al;
    ea = base + {{16{off[15]}}, off};
    al = (ea[1:0] == 2'b00);
    for (int k = 0; k < 4; k++) exp_lanes[8*k +: 8] = word_byte(data, k, be);
    exp_load = ref_load(ea, be);
    @(negedge clk);
    cfg_big_endian = be; req_valid = 1'b1; req_store = st;
    req_base = base; req_offset = off; req_reg = idx; req_wdata = data;
    #1;
    chk(req_ready == 1'b1, "R6 ready idle", 32'(req_ready), 32'd1);
    chk(mem_req == al, al ? "R1 mem_req" : "R5 mem_req", 32'(mem_req), 32'(al));
    if (al) chk(mem_addr == ea, "R1 address", mem_addr, ea);
    chk(mem_we == ((st && al) ? 4'hF : 4'h0), st ? "R2 we" : "R5 we", 32'(mem_we),
        32'((st && al) ? 4'hF : 4'h0));
    if (st && al) chk(mem_wdata == exp_lanes, "R4 store lanes", mem_wdata, exp_lanes);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(align_err == !al, "R5 align_err", 32'(align_err), 32'(!al));
    chk(wb_valid == (!st && al && idx != 0), (idx == 0) ? "R7 wb_valid" : "R3 wb_valid",
        32'(wb_valid), 32'(!st && al && idx != 0));
    if (!st && al && idx != 0) begin
      chk(wb_data == exp_load, "R4 load word", wb_data, exp_load);
      chk(wb_reg == idx, "R3 wb_reg", 32'(wb_reg), 32'(idx));
    end
    if (!st && al) chk(req_ready == 1'b0, "R6 ready pending", 32'(req_ready), 32'd0);
    if (st && al) for (int k = 0; k < 4; k++) ref_mem[ea + 32'(k)] = word_byte(data, k, be);
    if (!al) begin
      @(negedge clk); #1;
      chk(align_err == 1'b0, "R5 one-cycle pulse", 32'(align_err), 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_big_endian = 1'b0; req_valid = 1'b0; req_store = 1'b0;
    req_base = '0; req_offset = '0; req_reg = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(req_ready == 1'b1, "R9 ready", 32'(req_ready), 32'd1);
    chk(mem_req == 1'b0, "R9 mem_req", 32'(mem_req), 32'd0);
    chk(align_err == 1'b0, "R9 align_err", 32'(align_err), 32'd0);
    chk(wb_valid == 1'b0, "R9 wb_valid", 32'(wb_valid), 32'd0);

    // R2/R4: store little, read back both orders (R3)
    do_req(1'b1, 32'h0000_0100, 16'h0008, 5'd4, 32'h1122_3344, 1'b0);
    do_req(1'b0, 32'h0000_0100, 16'h0008, 5'd5, 32'h0, 1'b0);
    do_req(1'b0, 32'h0000_0100, 16'h0008, 5'd6, 32'h0, 1'b1);
    // R1: negative offset, big-endian store, little-endian load
    do_req(1'b1, 32'h0000_0200, 16'hFFFC, 5'd7, 32'hA1B2_C3D4, 1'b1);
    do_req(1'b0, 32'h0000_0200, 16'hFFFC, 5'd8, 32'h0, 1'b0);
    // R1: wrap across 2^32 both ways
    do_req(1'b1, 32'hFFFF_FFF8, 16'h0010, 5'd9, 32'hCAFE_F00D, 1'b0);
    do_req(1'b0, 32'h0000_0000, 16'h0008, 5'd10, 32'h0, 1'b1);
    do_req(1'b0, 32'h0000_0004, 16'hFFF8, 5'd11, 32'h0, 1'b0);
    // R5: misaligned store and load, then memory untouched
    do_req(1'b1, 32'h0000_0100, 16'h000A, 5'd12, 32'hDEAD_BEEF, 1'b0);
    do_req(1'b0, 32'h0000_0101, 16'h0000, 5'd13, 32'h0, 1'b1);
    do_req(1'b0, 32'h0000_0100, 16'h0008, 5'd14, 32'h0, 1'b0);
    do_req(1'b0, 32'h0000_0100, 16'h000C, 5'd15, 32'h0, 1'b0);
    // R7: load to index 0
    do_req(1'b0, 32'h0000_0100, 16'h0008, 5'd0, 32'h0, 1'b0);

    // R6/R8: request held during pending load, order flipped mid-flight
    @(negedge clk);
    cfg_big_endian = 1'b1; req_valid = 1'b1; req_store = 1'b0;
    req_base = 32'h0000_0100; req_offset = 16'h0008; req_reg = 5'd3;
    @(negedge clk);
    cfg_big_endian = 1'b0; req_store = 1'b1; req_base = 32'h0000_0300;
    req_offset = 16'h0000; req_wdata = 32'h5555_AAAA;
    #1;
    chk(req_ready == 1'b0, "R6 stalled ready", 32'(req_ready), 32'd0);
    chk(mem_req == 1'b0, "R6 no issue", 32'(mem_req), 32'd0);
    chk(mem_we == 4'h0, "R6 no write", 32'(mem_we), 32'd0);
    chk(wb_valid == 1'b1, "R8 wb_valid", 32'(wb_valid), 32'd1);
    chk(wb_data == ref_load(32'h108, 1'b1), "R8 captured order", wb_data, ref_load(32'h108, 1'b1));
    req_valid = 1'b0;
    do_req(1'b0, 32'h0000_0300, 16'h0000, 5'd2, 32'h0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule